// File: doc/BRIEF.md
# Precision Time-of-Day Clock with Fractional Rate Trim

This block keeps wall-clock time for a timing-protocol endpoint. On every cycle of its reference clock it adds a software-programmed rate word to a 64-bit fixed-point accumulator. The rate word is nanoseconds per cycle in 32.32 form. The integer half of the accumulator is the nanosecond-of-second. When that value would reach one second, exactly 10^9 ns is taken off and the remainder, fraction included, is kept. A 32-bit seconds counter advances on each such wrap.

Software reaches the block through a flat 64-bit register port. The rate word and the two pulse half-period words are read/write. The seconds counter is writable, and a write changes it without touching the nanosecond accumulator. The accumulator and a captured timestamp are read-only. The live time is also driven out as a packed word. A one-cycle capture strobe freezes that packed word so that both halves come from the same instant. A pulse-per-second output toggles at programmable points within each second.

The rate word resets to zero, so time stands still until software programs it.

Top module: `tod_clock`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the seconds counter, the capture register, the rate word and the pulse output. It loads both pulse half-period words with 500,000,000 in bits 63:32 and zero in bits 31:0. While the rate word is zero the time output does not move.
- R2: Each cycle the 32.32 rate word is added to the 64-bit accumulator. The nanosecond count is accumulator bits 63:32, and carries out of the fraction in bits 31:0 reach it.
- R3: A rate word written at a clock edge is not used at that edge. The accumulator update at the following edge uses it. The rate word reads back as written.
- R4: When the integer sum reaches or exceeds 1,000,000,000, that amount is subtracted and the excess is kept, including the fraction. 999,999,999 does not wrap, and exactly 1,000,000,000 becomes 0. The nanosecond count is always below 10^9.
- R5: Each nanosecond wrap raises the 32-bit seconds counter by one, modulo 2^32.
- R6: A write to the seconds register loads bits 31:0 of the write data and leaves the nanosecond accumulator untouched. If a wrap happens at the same edge, the written value wins.
- R7: The packed time word carries seconds in bits 63:32 and nanoseconds in bits 31:0. This holds for the `tod` output and for the capture register.
- R8: When `capture` is high at an edge, the capture register takes the packed time that was present just before that edge. It holds that value until the next capture.
- R9: The pulse output starts low and its next toggle point starts at 0 ns. The output toggles when the nanosecond count crosses the toggle point, with wraps into the next second handled. After toggling high the point advances by the high half-period (bits 63:32), after toggling low by the low half-period, modulo 10^9. With the reset defaults the pulse rises at each second wrap and falls at 500,000,000 ns.
- R10: Register addresses are byte offsets. Accumulator 0x00 (read-only, full 32.32), rate 0x08, capture 0x10 (read-only), seconds 0x18 (bits 31:0, upper read zero), pulse high 0x20, pulse low 0x28. Reads are combinational. Unmapped or misaligned addresses read zero. Writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| capture | input | 1 | Latch the packed time at this edge |
| tod | output | 64 | Live packed time {seconds, nanoseconds} |
| pps | output | 1 | Pulse-per-second output |

## Verification
The hardest cases to reach from the ports are the instants around the one-second boundary. These are the value one below 10^9, an exact landing on 10^9, an excess carrying a half-nanosecond fraction, and a seconds write that collides with a wrap. The bench reaches them in a few cycles by programming very large rate words (a quarter, a third, or just over three tenths of a second per cycle) right after reset. That makes each step's expected nanosecond and seconds value a simple product. The pulse edges and the seconds wrap past 2^32 use the same coarse rates, with a seconds preload for the latter.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam logic [32:0] NS_WRAP33 = 33'd1_000_000_000;
    localparam logic [64:0] NS_WRAP_FX = {33'd1_000_000_000, 32'd0};

    typedef enum logic [2:0] {
        RI_ACC   = 3'd0,
        RI_RATE  = 3'd1,
        RI_CAPT  = 3'd2,
        RI_SEC   = 3'd3,
        RI_PHI   = 3'd4,
        RI_PLO   = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic [31:0] sec;
        logic [31:0] ns;
    } tod_t;

    // Reduce a nanosecond value that may overshoot one second by at most one second.
    function automatic logic [31:0] ns_mod(input logic [32:0] v);
        logic [32:0] d;
        d = v - NS_WRAP33;
        return (v >= NS_WRAP33) ? d[31:0] : v[31:0];
    endfunction

    // True when the step from old_ns to new_ns passes the point mark.
    function automatic logic mark_crossed(input logic [31:0] old_ns,
                                          input logic [31:0] new_ns,
                                          input logic        wrapped,
                                          input logic [31:0] mark);
        if (wrapped)
            return (mark > old_ns) || (mark <= new_ns);
        return (mark > old_ns) && (mark <= new_ns);
    endfunction

endpackage

// File: rtl/tod_accum.sv
module tod_accum
    import tod_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] rate,
    input  logic        sec_wr,
    input  logic [31:0] sec_wdata,
    output logic [63:0] acc_q,
    output logic [63:0] acc_nxt,
    output logic        wrap_nxt,
    output logic [31:0] sec_q
);

    logic [64:0] sum;
    logic [64:0] reduced;

    always_comb begin
        sum      = {1'b0, acc_q} + {1'b0, rate};
        wrap_nxt = (sum[64:32] >= NS_WRAP33);
        reduced  = sum - NS_WRAP_FX;
        acc_nxt  = wrap_nxt ? reduced[63:0] : sum[63:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            sec_q <= '0;
        end else begin
            acc_q <= acc_nxt;
            if (sec_wr)
                sec_q <= sec_wdata;
            else if (wrap_nxt)
                sec_q <= sec_q + 32'd1;
        end
    end

endmodule

// File: rtl/tod_pps.sv
module tod_pps
    import tod_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ns_old,
    input  logic [31:0] ns_new,
    input  logic        wrapped,
    input  logic [31:0] high_ns,
    input  logic [31:0] low_ns,
    output logic        pps
);

    logic [31:0] mark_q;
    logic        hit;
    logic        lvl_nxt;
    logic [31:0] step;
    logic [31:0] mark_nxt;

    always_comb begin
        hit      = mark_crossed(ns_old, ns_new, wrapped, mark_q);
        lvl_nxt  = ~pps;
        step     = lvl_nxt ? high_ns : low_ns;
        mark_nxt = ns_mod({1'b0, mark_q} + {1'b0, step});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pps    <= 1'b0;
            mark_q <= '0;
        end else if (hit) begin
            pps    <= lvl_nxt;
            mark_q <= mark_nxt;
        end
    end

endmodule

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [31:0] PPS_HALF = 32'd500_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       wdata,
    input  logic [63:0]       acc,
    input  logic [31:0]       sec,
    input  logic              capture,
    output logic [63:0]       rate_q,
    output logic [63:0]       phi_q,
    output logic [63:0]       plo_q,
    output logic [63:0]       capt_q,
    output logic              sec_wr,
    output logic [31:0]       sec_wdata,
    output logic [63:0]       rdata
);

    localparam int          IDX_W   = ADDR_W - 3;
    localparam logic [63:0] PPS_DEF = {PPS_HALF, 32'd0};

    logic             aligned;
    logic [IDX_W-1:0] idx;
    logic             sel_rate, sel_sec, sel_phi, sel_plo;
    tod_t             live;

    always_comb begin
        aligned  = (addr[2:0] == 3'b000);
        idx      = addr[ADDR_W-1:3];
        sel_rate = aligned && (idx == IDX_W'(RI_RATE));
        sel_sec  = aligned && (idx == IDX_W'(RI_SEC));
        sel_phi  = aligned && (idx == IDX_W'(RI_PHI));
        sel_plo  = aligned && (idx == IDX_W'(RI_PLO));
        live.sec = sec;
        live.ns  = acc[63:32];
    end

    assign sec_wr    = wr && sel_sec;
    assign sec_wdata = wdata[31:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            phi_q  <= PPS_DEF;
            plo_q  <= PPS_DEF;
            capt_q <= '0;
        end else begin
            if (wr && sel_rate) rate_q <= wdata;
            if (wr && sel_phi)  phi_q  <= wdata;
            if (wr && sel_plo)  plo_q  <= wdata;
            if (capture)        capt_q <= live;
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(RI_ACC):  rdata = acc;
                IDX_W'(RI_RATE): rdata = rate_q;
                IDX_W'(RI_CAPT): rdata = capt_q;
                IDX_W'(RI_SEC):  rdata = {32'd0, sec};
                IDX_W'(RI_PHI):  rdata = phi_q;
                IDX_W'(RI_PLO):  rdata = plo_q;
                default:         rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [31:0] PPS_HALF = 32'd500_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              capture,
    output logic [63:0]       tod,
    output logic              pps
);

    logic [63:0] rate_w, phi_w, plo_w, capt_w;
    logic [63:0] acc_w, acc_nxt_w;
    logic        wrap_w;
    logic [31:0] sec_w;
    logic        sec_wr_w;
    logic [31:0] sec_wdata_w;
    tod_t        now;

    tod_regs #(.ADDR_W(ADDR_W), .PPS_HALF(PPS_HALF)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .acc       (acc_w),
        .sec       (sec_w),
        .capture   (capture),
        .rate_q    (rate_w),
        .phi_q     (phi_w),
        .plo_q     (plo_w),
        .capt_q    (capt_w),
        .sec_wr    (sec_wr_w),
        .sec_wdata (sec_wdata_w),
        .rdata     (reg_rdata)
    );

    tod_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .rate      (rate_w),
        .sec_wr    (sec_wr_w),
        .sec_wdata (sec_wdata_w),
        .acc_q     (acc_w),
        .acc_nxt   (acc_nxt_w),
        .wrap_nxt  (wrap_w),
        .sec_q     (sec_w)
    );

    tod_pps u_pps (
        .clk     (clk),
        .rst     (rst),
        .ns_old  (acc_w[63:32]),
        .ns_new  (acc_nxt_w[63:32]),
        .wrapped (wrap_w),
        .high_ns (phi_w[63:32]),
        .low_ns  (plo_w[63:32]),
        .pps     (pps)
    );

    always_comb begin
        now.sec = sec_w;
        now.ns  = acc_w[63:32];
    end

    assign tod = now;

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              capture,
    input logic [63:0]       tod,
    input logic              pps,
    input logic [63:0]       rate,
    input logic [63:0]       acc,
    input logic [63:0]       capt
);

    localparam logic [ADDR_W-1:0] SEC_ADDR = ADDR_W'(8 * int'(RI_SEC));

    logic sec_write;
    assign sec_write = reg_wr && (reg_addr == SEC_ADDR);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (tod == 64'd0 && !pps && capt == 64'd0 && rate == 64'd0)); // R1

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rate == 64'd0) |=> $stable(acc)); // R2

    AST_NS_BELOW_SEC: assert property (@(posedge clk) disable iff (rst)
        tod[31:0] < 32'd1_000_000_000); // R4

    AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!$past(sec_write) && tod[31:0] < $past(tod[31:0]))
            |-> tod[63:32] == $past(tod[63:32]) + 32'd1); // R5

    AST_CAPTURE_TAKE: assert property (@(posedge clk) disable iff (rst)
        capture |=> capt == $past(tod)); // R8

endmodule

bind tod_clock tod_clock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .capture  (capture),
    .tod      (tod),
    .pps      (pps),
    .rate     (rate_w),
    .acc      (acc_w),
    .capt     (capt_w)
);

// File: tb/tod_clock_tb.sv
`timescale 1ns/1ps
module tod_clock_tb;

    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] A_ACC  = 6'h00;
    localparam logic [ADDR_W-1:0] A_RATE = 6'h08;
    localparam logic [ADDR_W-1:0] A_CAPT = 6'h10;
    localparam logic [ADDR_W-1:0] A_SEC  = 6'h18;
    localparam logic [ADDR_W-1:0] A_PHI  = 6'h20;
    localparam logic [ADDR_W-1:0] A_PLO  = 6'h28;
    localparam longint BILLION = 64'd1_000_000_000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;
    logic              capture = 1'b0;
    logic [63:0]       tod;
    logic              pps;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tod_clock #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .capture(capture),
        .tod(tod), .pps(pps)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Returns at the negedge just after the write edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [63:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        do_reset();
        chk("R1 tod after reset", tod, 64'd0);
        chk("R1 pps after reset", {63'd0, pps}, 64'd0);
        rd(A_RATE, d); chk("R1 rate reset", d, 64'd0);
        rd(A_PHI, d);  chk("R1 high half reset", d, {32'd500_000_000, 32'd0});
        rd(A_PLO, d);  chk("R1 low half reset", d, {32'd500_000_000, 32'd0});
        rd(A_CAPT, d); chk("R1 capture reset", d, 64'd0);
        rd(A_SEC, d);  chk("R1 seconds reset", d, 64'd0);
        repeat (10) @(negedge clk);
        chk("R1 stopped with zero rate", tod, 64'd0);
    endtask

    task automatic t_integer();
        logic [63:0] d;
        do_reset();
        wr(A_RATE, {32'd5, 32'd0});
        chk("R3 rate unused at write edge", tod, 64'd0);
        rd(A_RATE, d); chk("R3 rate readback", d, {32'd5, 32'd0});
        @(negedge clk);
        chk("R2 one step", tod, 64'd5);
        repeat (9) @(negedge clk);
        chk("R2 ten steps", tod, 64'd50);
    endtask

    task automatic t_fraction();
        logic [63:0] d;
        do_reset();
        wr(A_RATE, 64'h0000_0002_8000_0000);
        @(negedge clk); chk("R2 frac step1", tod, 64'd2);
        @(negedge clk); chk("R2 frac step2", tod, 64'd5);
        @(negedge clk); chk("R2 frac step3", tod, 64'd7);
        @(negedge clk); chk("R2 frac step4", tod, 64'd10);
        rd(A_ACC, d); chk("R2 full accumulator", d, {32'd10, 32'd0});
    endtask

    task automatic t_rate_change();
        do_reset();
        wr(A_RATE, {32'd5, 32'd0});
        @(negedge clk);
        wr(A_RATE, {32'd7, 32'd0});
        chk("R3 old rate at write edge", tod, 64'd15);
        @(negedge clk);
        chk("R3 new rate next edge", tod, 64'd22);
    endtask

    task automatic t_rollover(input longint c);
        do_reset();
        wr(A_RATE, {c[31:0], 32'd0});
        for (int k = 1; k <= 4; k++) begin
            longint e;
            @(negedge clk);
            e = c * k;
            chk("R4 nanoseconds", {32'd0, tod[31:0]}, 64'(e % BILLION));
            chk("R5 seconds", {32'd0, tod[63:32]}, 64'(e / BILLION));
        end
    endtask

    task automatic t_frac_excess();
        logic [63:0] d;
        do_reset();
        wr(A_RATE, {32'd333_333_333, 32'h8000_0000});
        repeat (3) @(negedge clk);
        chk("R4 wrap keeps fraction tod", tod, {32'd1, 32'd0});
        rd(A_ACC, d); chk("R4 wrap keeps fraction acc", d, 64'h0000_0000_8000_0000);
    endtask

    task automatic t_sec_wrap();
        do_reset();
        wr(A_SEC, 64'h0000_0000_FFFF_FFFF);
        wr(A_RATE, {32'd250_000_000, 32'd0});
        repeat (4) @(negedge clk);
        chk("R5 seconds wrap modulo 2^32", tod, 64'd0);
    endtask

    task automatic t_sec_write();
        do_reset();
        wr(A_RATE, {32'd5, 32'd0});
        repeat (3) @(negedge clk);
        wr(A_SEC, 64'hFFFF_0000_1234_5678);
        chk("R6 seconds loaded ns untouched", tod, {32'h1234_5678, 32'd25});
        do_reset();
        wr(A_RATE, {32'd250_000_000, 32'd0});
        repeat (2) @(negedge clk);
        wr(A_SEC, 64'd100);
        chk("R6 write wins over wrap", tod, {32'd100, 32'd0});
        repeat (4) @(negedge clk);
        chk("R6 counting resumes", tod, {32'd101, 32'd0});
    endtask

    task automatic t_readonly();
        logic [63:0] d;
        do_reset();
        wr(A_RATE, {32'd5, 32'd0});
        wr(A_ACC, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R10 accumulator write ignored", tod, 64'd10);
        wr(A_CAPT, 64'h1111_2222_3333_4444);
        rd(A_CAPT, d); chk("R10 capture write ignored", d, 64'd0);
        rd(6'h30, d); chk("R10 unmapped reads zero", d, 64'd0);
        rd(6'h09, d); chk("R10 misaligned reads zero", d, 64'd0);
    endtask

    task automatic t_capture();
        logic [63:0] snap, d;
        do_reset();
        wr(A_RATE, {32'd7, 32'd0});
        repeat (5) @(negedge clk);
        snap = tod;
        chk("R7 packed live time", snap, {32'd0, 32'd35});
        capture = 1'b1;
        @(negedge clk);
        capture = 1'b0;
        rd(A_CAPT, d); chk("R8 capture value", d, snap);
        repeat (5) @(negedge clk);
        rd(A_CAPT, d); chk("R8 capture holds", d, snap);
        do_reset();
        wr(A_RATE, {32'd250_000_000, 32'd0});
        repeat (5) @(negedge clk);
        capture = 1'b1;
        @(negedge clk);
        capture = 1'b0;
        rd(A_CAPT, d); chk("R7 captured seconds and ns", d, {32'd1, 32'd250_000_000});
    endtask

    task automatic t_pps(input bit custom);
        do_reset();
        if (custom) begin
            logic [63:0] d;
            wr(A_PHI, {32'd250_000_000, 32'd0});
            wr(A_PLO, {32'd750_000_000, 32'd0});
            rd(A_PHI, d); chk("R9 high half readback", d, {32'd250_000_000, 32'd0});
        end
        wr(A_RATE, {32'd250_000_000, 32'd0});
        chk("R9 pps starts low", {63'd0, pps}, 64'd0);
        for (int k = 1; k <= 8; k++) begin
            bit e;
            @(negedge clk);
            if (custom) e = (k % 4) == 0;
            else        e = (k >= 4) && ((k % 4) == 0 || (k % 4) == 1);
            chk(custom ? "R9 pps custom halves" : "R9 pps default halves",
                {63'd0, pps}, {63'd0, e});
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_integer();
        t_fraction();
        t_rate_change();
        t_rollover(64'd250_000_000);
        t_rollover(64'd333_333_333);
        t_rollover(64'd300_000_001);
        t_frac_excess();
        t_sec_wrap();
        t_sec_write();
        t_readonly();
        t_capture();
        t_pps(1'b0);
        t_pps(1'b1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule